// File: doc/BRIEF.md
# Configurable Aspect Dual-Port RAM

This block is a 256-bit memory with one write-only port and one read-only port. Each port has its own clock. A static configuration input chooses between two shapes: 32 words of 8 bits (byte mode) or 64 words of 4 bits (nibble mode). Each port also has its own polarity input, so that port can act on the rising or the falling edge of its clock.

Physically the array is 32 rows of 8 bits. Address bits [4:0] pick the row. In nibble mode, address bit 5 picks the half of the row: 1 picks bits [7:4] and 0 picks bits [3:0]. In byte mode, address bit 5 is ignored.

Writes are synchronous and gated by a write enable. Reads are registered and gated by a read enable. The read register is the only state that the active-low reset clears. The configuration inputs may change only while both enables are low.

Top module: `aspect_dpram`

## Requirements
- R1: In byte mode (`nibble_mode`=0), a write stores all 8 bits of `wr_data` in row `wr_addr[4:0]`, and a later read of that row returns all 8 bits.
- R2: In byte mode, address bit 5 has no effect on either port. Addresses that differ only in bit 5 reach the same row.
- R3: In nibble mode (`nibble_mode`=1), a write stores `wr_data[3:0]` into one half of row `wr_addr[4:0]`. The half is bits [7:4] when `wr_addr[5]`=1 and bits [3:0] when `wr_addr[5]`=0. The other half of the row keeps its value.
- R4: In nibble mode, `rd_data[3:0]` holds the half of row `rd_addr[4:0]` chosen by `rd_addr[5]`, and `rd_data[7:4]` is 0.
- R5: A write takes place only on an active write edge while `wr_en`=1. With `wr_en`=0, the stored contents do not change.
- R6: `rd_data` is loaded on an active read edge while `rd_en`=1, and holds its value while `rd_en`=0.
- R7: When a write and a read of the same location fall on the same active edge, the read returns the data stored before that write.
- R8: A polarity input of 0 makes its port act on the rising edge of its clock, and 1 makes it act on the falling edge. The two ports are set independently.
- R9: While `rst_n`=0, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the read data register |
| nibble_mode | input | 1 | Static shape select: 0 = 32x8, 1 = 64x4 |
| wr_clk | input | 1 | Write port clock |
| wr_clk_inv | input | 1 | Write edge select: 0 = rising, 1 = falling |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data (bits [3:0] only in nibble mode) |
| rd_clk | input | 1 | Read port clock |
| rd_clk_inv | input | 1 | Read edge select: 0 = rising, 1 = falling |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Registered read data |

## Verification
A write and a read can fall in the same cycle. When they target the same row, the order of the two edges decides which data the read returns. The bench drives both port clocks from one clock and steps through all four polarity settings. It issues same-address and nearby-address write/read pairs, both directed and random over a narrow address range. A reference model decides the order in each cycle: the read sees the new data only when the write acts on the falling edge and the read on the following rising edge. In every other setting the read sees the old data, and each returned byte is compared against the model.

// File: rtl/aspect_ram_pkg.sv
`timescale 1ns/1ps
package aspect_ram_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = DATA_W / LANES;
  localparam int unsigned ROW_AW = ADDR_W - 1;
  localparam int unsigned ROWS   = 1 << ROW_AW;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [ROW_AW-1:0] row_t;

  // physical row reached by an address in either mode
  function automatic row_t row_of(addr_t a);
    return a[ROW_AW-1:0];
  endfunction

  // half-row selector used in nibble mode
  function automatic logic lane_of(addr_t a);
    return a[ADDR_W-1];
  endfunction

  // does a write at address a touch lane l
  function automatic logic lane_hit(addr_t a, logic nib, int l);
    return !nib || (lane_of(a) == l[0]);
  endfunction

  // data delivered to lane l of the addressed row
  function automatic lane_t lane_wdata(word_t d, logic nib, int l);
    return nib ? d[LANE_W-1:0] : d[l*LANE_W +: LANE_W];
  endfunction

  // word presented at the read port for a given physical row
  function automatic word_t read_view(word_t row, addr_t a, logic nib);
    if (!nib) return row;
    return {LANE_W'(0), lane_of(a) ? row[DATA_W-1 -: LANE_W] : row[LANE_W-1:0]};
  endfunction
endpackage

// File: rtl/edge_select.sv
`timescale 1ns/1ps
module edge_select (
  input  logic clk,
  input  logic inv,
  output logic clk_eff
);
  // rising edge of clk_eff is the active edge of the port
  assign clk_eff = clk ^ inv;
endmodule

// File: rtl/aspect_ram_array.sv
`timescale 1ns/1ps
module aspect_ram_array
  import aspect_ram_pkg::*;
(
  input  logic  wr_clk_eff,
  input  logic  rst_n,
  input  logic  nibble_mode,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  word_t wr_data,
  input  row_t  rd_row,
  output word_t rd_row_data
);
  word_t mem [ROWS];

  row_t              wr_row;
  word_t             cur_row;
  lane_t             kept_nib;
  logic [LANES-1:0]  lane_we;
  lane_t             lane_wd [LANES];

  assign wr_row   = row_of(wr_addr);
  assign cur_row  = mem[wr_row];
  assign kept_nib = lane_of(wr_addr) ? cur_row[LANE_W-1:0] : cur_row[DATA_W-1 -: LANE_W];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = wr_en && lane_hit(wr_addr, nibble_mode, g);
    assign lane_wd[g] = lane_wdata(wr_data, nibble_mode, g);
  end

  always_ff @(posedge wr_clk_eff) begin
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l]) mem[wr_row][l*LANE_W +: LANE_W] <= lane_wd[l];
    end
  end

  assign rd_row_data = mem[rd_row];

  // R1 R2
  byte_write_chk: assert property (@(posedge wr_clk_eff) disable iff (!rst_n)
    (wr_en && !nibble_mode) |=> mem[$past(wr_row)] == $past(wr_data));

  // R3
  nib_keep_chk: assert property (@(posedge wr_clk_eff) disable iff (!rst_n)
    (wr_en && nibble_mode) |=>
      (($past(lane_of(wr_addr)) ? mem[$past(wr_row)][LANE_W-1:0]
                                 : mem[$past(wr_row)][DATA_W-1 -: LANE_W]) == $past(kept_nib)));

  // R5
  idle_write_chk: assert property (@(posedge wr_clk_eff) disable iff (!rst_n)
    !wr_en |=> mem[$past(wr_row)] == $past(cur_row));
endmodule

// File: rtl/aspect_ram_rdport.sv
`timescale 1ns/1ps
module aspect_ram_rdport
  import aspect_ram_pkg::*;
(
  input  logic  rd_clk_eff,
  input  logic  rst_n,
  input  logic  nibble_mode,
  input  logic  rd_en,
  input  addr_t rd_addr,
  input  word_t row_data,
  output row_t  rd_row,
  output word_t rd_data
);
  word_t view;

  assign rd_row = row_of(rd_addr);
  assign view   = read_view(row_data, rd_addr, nibble_mode);

  always_ff @(posedge rd_clk_eff or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= view;
  end

  // R6
  rd_hold_chk: assert property (@(posedge rd_clk_eff) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R4
  nib_upper_zero_chk: assert property (@(posedge rd_clk_eff) disable iff (!rst_n)
    (rd_en && nibble_mode) |=> rd_data[DATA_W-1 -: LANE_W] == '0);
endmodule

// File: rtl/aspect_dpram.sv
`timescale 1ns/1ps
module aspect_dpram
  import aspect_ram_pkg::*;
(
  input  logic              rst_n,
  input  logic              nibble_mode,
  input  logic              wr_clk,
  input  logic              wr_clk_inv,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_clk_inv,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic  wr_clk_eff;
  logic  rd_clk_eff;
  row_t  rd_row;
  word_t rd_row_data;

  // R8: each port picks its own active edge
  edge_select u_wr_edge (.clk(wr_clk), .inv(wr_clk_inv), .clk_eff(wr_clk_eff));
  edge_select u_rd_edge (.clk(rd_clk), .inv(rd_clk_inv), .clk_eff(rd_clk_eff));

  aspect_ram_array u_array (
    .wr_clk_eff (wr_clk_eff),
    .rst_n      (rst_n),
    .nibble_mode(nibble_mode),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_row     (rd_row),
    .rd_row_data(rd_row_data)
  );

  // R7: the read samples the array before a write on the same edge lands
  aspect_ram_rdport u_rdport (
    .rd_clk_eff (rd_clk_eff),
    .rst_n      (rst_n),
    .nibble_mode(nibble_mode),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .row_data   (rd_row_data),
    .rd_row     (rd_row),
    .rd_data    (rd_data)
  );
endmodule

// File: tb/aspect_dpram_test.sv
`timescale 1ns/1ps
module aspect_dpram_test;
  logic       clk = 1'b0;
  logic       rst_n, nibble_mode, wr_clk_inv, rd_clk_inv;
  logic       wr_en, rd_en;
  logic [5:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;
  logic [7:0]  ref_mem [32];
  logic [7:0]  exp_rd;

  always #4 clk = ~clk;

  aspect_dpram uut (
    .rst_n(rst_n), .nibble_mode(nibble_mode),
    .wr_clk(clk), .wr_clk_inv(wr_clk_inv), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(clk), .rd_clk_inv(rd_clk_inv), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] model_read(logic [5:0] a);
    logic [7:0] row = ref_mem[a[4:0]];
    if (!nibble_mode) return row;
    return a[5] ? {4'h0, row[7:4]} : {4'h0, row[3:0]};
  endfunction

  task automatic model_write(logic [5:0] a, logic [7:0] d);
    if (!nibble_mode)  ref_mem[a[4:0]] = d;
    else if (a[5])     ref_mem[a[4:0]][7:4] = d[3:0];
    else               ref_mem[a[4:0]][3:0] = d[3:0];
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // one cycle; read-before-write unless write is on the falling edge and read on the next rising one
  task automatic do_cycle(logic we, logic [5:0] wa, logic [7:0] wd,
                          logic re, logic [5:0] ra, string tag);
    logic rd_first;
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    rd_first = !(wr_clk_inv && !rd_clk_inv);
    if (rd_first && re) exp_rd = model_read(ra);
    if (we) model_write(wa, wd);
    if (!rd_first && re) exp_rd = model_read(ra);
    tick();
    wr_en = 1'b0; rd_en = 1'b0;
    check(tag, rd_data, exp_rd);
  endtask

  task automatic set_cfg(logic nib, logic wi, logic ri);
    wr_en = 1'b0; rd_en = 1'b0;
    nibble_mode = nib; wr_clk_inv = wi; rd_clk_inv = ri;
    tick();
    tick();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; nibble_mode = 1'b0; wr_clk_inv = 1'b0; rd_clk_inv = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    exp_rd = 8'h00;
    tick(); tick(); tick();
    check("R9 reset", rd_data, 8'h00);
    rst_n = 1'b1;
    tick();

    for (int r = 0; r < 32; r++) do_cycle(1'b1, 6'(r), 8'(r * 37 + 5), 1'b0, 6'd0, "R6 fill");

    // R1 byte write and read back
    do_cycle(1'b1, 6'h0A, 8'hA5, 1'b0, 6'h00, "R6");
    do_cycle(1'b0, 6'h00, 8'h00, 1'b1, 6'h0A, "R1");
    // R2 bit 5 ignored on both ports
    do_cycle(1'b1, 6'h2B, 8'h3C, 1'b0, 6'h00, "R6");
    do_cycle(1'b0, 6'h00, 8'h00, 1'b1, 6'h0B, "R2");
    do_cycle(1'b0, 6'h00, 8'h00, 1'b1, 6'h2B, "R2");
    // R5 disabled write leaves row untouched
    do_cycle(1'b0, 6'h0B, 8'hFF, 1'b1, 6'h0B, "R5");
    do_cycle(1'b0, 6'h00, 8'h00, 1'b1, 6'h2B, "R5");
    // R6 hold with read disabled
    do_cycle(1'b0, 6'h00, 8'h00, 1'b0, 6'h0A, "R6");
    // R7 same edge same address: old data, then new
    do_cycle(1'b1, 6'h0C, 8'h11, 1'b1, 6'h0C, "R7");
    do_cycle(1'b0, 6'h00, 8'h00, 1'b1, 6'h0C, "R7");

    // R3 R4 nibble mode
    set_cfg(1'b1, 1'b0, 1'b0);
    do_cycle(1'b1, 6'h23, 8'hF9, 1'b0, 6'h00, "R6");
    do_cycle(1'b0, 6'h00, 8'h00, 1'b1, 6'h23, "R4");
    do_cycle(1'b0, 6'h00, 8'h00, 1'b1, 6'h03, "R4");
    do_cycle(1'b1, 6'h04, 8'hE6, 1'b1, 6'h04, "R7");
    do_cycle(1'b0, 6'h00, 8'h00, 1'b1, 6'h04, "R4");
    set_cfg(1'b0, 1'b0, 1'b0);
    do_cycle(1'b0, 6'h00, 8'h00, 1'b1, 6'h03, "R3");
    do_cycle(1'b0, 6'h00, 8'h00, 1'b1, 6'h04, "R3");

    // R8 edge selection per port
    set_cfg(1'b0, 1'b1, 1'b0);
    do_cycle(1'b1, 6'h0D, 8'h5A, 1'b1, 6'h0D, "R8 falling write");
    set_cfg(1'b0, 1'b0, 1'b1);
    do_cycle(1'b1, 6'h0D, 8'h77, 1'b1, 6'h0D, "R8 falling read");
    do_cycle(1'b0, 6'h00, 8'h00, 1'b1, 6'h0D, "R8");
    set_cfg(1'b0, 1'b1, 1'b1);
    do_cycle(1'b1, 6'h0D, 8'h99, 1'b1, 6'h0D, "R8 both falling");
    do_cycle(1'b0, 6'h00, 8'h00, 1'b1, 6'h0D, "R8");

    // random traffic over a narrow address range, all configurations
    for (int cfg = 0; cfg < 8; cfg++) begin
      set_cfg(cfg[2], cfg[1], cfg[0]);
      for (int i = 0; i < 300; i++) begin
        logic [5:0] wa, ra;
        wa = {1'($urandom), 2'b00, 3'($urandom)};
        ra = ($urandom % 3 == 0) ? wa : {1'($urandom), 2'b00, 3'($urandom)};
        do_cycle(1'($urandom), wa, 8'($urandom), 1'($urandom % 4 != 0), ra,
                 cfg[2] ? "R4 random" : "R1 random");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule